// File: doc/BRIEF.md
# Multi-Scale Pin Input Debounce Filter

This block cleans up one slowly varying pad input before it reaches status and interrupt logic. It runs on a slow real-time clock of about 32.768 kHz. The raw pad level first passes through a two-stage synchroniser. A filter then decides when the clean output level may follow the synchronised level.

A configuration write loads three fields at once: a mode, a 4-bit tick count and a 2-bit tick scale. The filter window is the tick count times the tick length. The scale picks a tick of 2, 8, 512 or 2048 slow-clock cycles, so windows range from about 61 µs up to about 1 s. The modes are: no filtering; filtering of both edges; or filtering of only one edge while the other edge passes at once. Every configuration write restarts the filter from the present synchronised level.

Top module: `gpio_db_filter`

## Requirements
- R1: After reset, `level_o` is 0 and the mode is bypass (mode code 00).
- R2: In bypass mode (mode 00), `level_o` follows `pad_i` three clock edges after the pad changes. The tick count and tick scale have no effect in this mode.
- R3: The tick length is 2, 8, 512 or 2048 clock cycles for `cfg_scale` values 0, 1, 2 and 3. `cfg_scale[1]` selects the large range and `cfg_scale[0]` selects the longer unit within that range.
- R4: In both-edge mode (mode 01) with count N > 0 and tick length T, a pad change that is held steady reaches `level_o` after N*T+2 edges, counted from the first edge after the change.
- R5: In any filtering mode, when the synchronised input equals `level_o`, the output holds. A pulse shorter than the window never reaches the output. A reversal before the window has elapsed restarts the count from zero.
- R6: In keep-low mode (mode 10), a falling input reaches `level_o` after three edges. A rising input needs the full window, as in R4.
- R7: In keep-high mode (mode 11), a rising input reaches `level_o` after three edges. A falling input needs the full window.
- R8: A configuration write (`cfg_we`) clears the tick prescaler and the stability count. At that same edge, `level_o` takes the current synchronised input.
- R9: In a filtering mode with a tick count of 0, both edges pass with the bypass latency of three edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow real-time clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | 1 | Raw, asynchronous pad level |
| cfg_we | input | 1 | Load strobe for the three configuration fields |
| cfg_count | input | 4 | Window length in ticks |
| cfg_scale | input | 2 | Tick length select: {large, unit} |
| cfg_type | input | 2 | Mode: 00 bypass, 01 both edges, 10 keep low, 11 keep high |
| level_o | output | 1 | Filtered level |

## Verification
Each result has a fixed due time. The output takes the synchronised input one edge after a configuration write. Unfiltered edges take three edges. A filtered edge takes N*T+2 edges, counted from the first edge after the pad changes, because the synchroniser adds two edges and the last tick lands on the (N*T)th edge that sees a difference.

The bench drives and samples on falling edges. It counts the falling edges until the output reaches the new level and compares that count with the value computed from mode, count, scale and edge direction. For pulses that must be rejected, the bench watches the output for a span longer than the pulse plus the window.

// File: rtl/gdb_pkg.sv
`timescale 1ns/1ps
package gdb_pkg;

    // Filter mode; the encoding is decoded by the register interface
    typedef enum logic [1:0] {
        FLT_OFF       = 2'b00,
        FLT_BOTH      = 2'b01,
        FLT_KEEP_LOW  = 2'b10,
        FLT_KEEP_HIGH = 2'b11
    } flt_mode_e;

endpackage

// File: rtl/gdb_sync.sv
`timescale 1ns/1ps
module gdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gdb_prescaler.sv
`timescale 1ns/1ps
module gdb_prescaler #(
    parameter int TICK_S0 = 2,
    parameter int TICK_S1 = 8,
    parameter int TICK_S2 = 512,
    parameter int TICK_S3 = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,     // hold at zero
    input  logic [1:0] scale,
    output logic       tick
);
    localparam int PRE_W = $clog2(TICK_S3);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        case (scale)
            2'd0:    last = PRE_W'(TICK_S0 - 1);
            2'd1:    last = PRE_W'(TICK_S1 - 1);
            2'd2:    last = PRE_W'(TICK_S2 - 1);
            default: last = PRE_W'(TICK_S3 - 1);
        endcase
        tick  = 1'b0;
        pre_d = pre_q + 1'b1;
        if (clr) begin
            pre_d = '0;
        end else if (pre_q == last) begin
            tick  = 1'b1;
            pre_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/gdb_core.sv
`timescale 1ns/1ps
module gdb_core
    import gdb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl,
    input  logic             reload,
    input  flt_mode_e        mode,
    input  logic [CNT_W-1:0] win,
    input  logic             tick,
    output logic             run,
    output logic             level
);
    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t cur_q, cur_d;
    logic  differ, pass_now;

    always_comb begin
        cur_d    = cur_q;
        run      = 1'b0;
        differ   = sync_lvl != cur_q.out;
        pass_now = (mode == FLT_KEEP_LOW  && !sync_lvl) ||
                   (mode == FLT_KEEP_HIGH &&  sync_lvl) ||
                   (win == '0);
        if (reload || mode == FLT_OFF) begin
            cur_d.out = sync_lvl;
            cur_d.cnt = '0;
        end else if (!differ) begin
            cur_d.cnt = '0;
        end else if (pass_now) begin
            cur_d.out = sync_lvl;
            cur_d.cnt = '0;
        end else begin
            run = 1'b1;
            if (tick) begin
                if ({1'b0, cur_q.cnt} + 1'b1 == {1'b0, win}) begin
                    cur_d.out = sync_lvl;
                    cur_d.cnt = '0;
                end else begin
                    cur_d.cnt = cur_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign level = cur_q.out;
endmodule

// File: rtl/gpio_db_filter.sv
`timescale 1ns/1ps
module gpio_db_filter
    import gdb_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SYNC_N  = 2,
    parameter int TICK_S0 = 2,
    parameter int TICK_S1 = 8,
    parameter int TICK_S2 = 512,
    parameter int TICK_S3 = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_i,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_scale,
    input  logic [1:0]       cfg_type,
    output logic             level_o
);
    typedef struct packed {
        flt_mode_e        mode;
        logic [1:0]       scale;
        logic [CNT_W-1:0] win;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic sync_lvl, tick, run;
    logic [1:0] mode_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.mode  = flt_mode_e'(cfg_type);
            cfg_d.scale = cfg_scale;
            cfg_d.win   = cfg_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mode: FLT_OFF, scale: 2'd0, win: '0};
        else        cfg_q <= cfg_d;
    end

    assign mode_q = cfg_q.mode;

    gdb_sync #(.STAGES(SYNC_N)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_i),
        .dout (sync_lvl)
    );

    gdb_prescaler #(
        .TICK_S0(TICK_S0), .TICK_S1(TICK_S1),
        .TICK_S2(TICK_S2), .TICK_S3(TICK_S3)
    ) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cfg_we || !run),
        .scale(cfg_q.scale),
        .tick (tick)
    );

    gdb_core #(.CNT_W(CNT_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_lvl(sync_lvl),
        .reload  (cfg_we),
        .mode    (cfg_q.mode),
        .win     (cfg_q.win),
        .tick    (tick),
        .run     (run),
        .level   (level_o)
    );
endmodule

// File: rtl/gdb_checker.sv
`timescale 1ns/1ps
module gdb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       sync_lvl,
    input logic [1:0] mode,
    input logic       level_o
);
    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> level_o == $past(sync_lvl));                                  // R8
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode == 2'b00) |=> level_o == $past(sync_lvl));              // R2
    AST_HOLD_WHEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode != 2'b00 && sync_lvl == level_o) |=> $stable(level_o)); // R5
    AST_KEEP_LOW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode == 2'b10 && level_o && !sync_lvl) |=> !level_o);        // R6
    AST_KEEP_HIGH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && mode == 2'b11 && !level_o && sync_lvl) |=> level_o);         // R7
endmodule

bind gpio_db_filter gdb_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .sync_lvl(sync_lvl),
    .mode    (mode_q),
    .level_o (level_o)
);

// File: tb/test_gpio_db_filter.sv
`timescale 1ns/1ps
module test_gpio_db_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_count = '0;
    logic [1:0] cfg_scale = '0;
    logic [1:0] cfg_type = '0;
    logic       level_o;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio_db_filter i_gpio_db_filter (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .cfg_we(cfg_we),
        .cfg_count(cfg_count), .cfg_scale(cfg_scale), .cfg_type(cfg_type),
        .level_o(level_o)
    );

    function automatic int exp_lat(int ty, int cn, int sc, bit nv);
        int t;
        t = (sc == 0) ? 2 : (sc == 1) ? 8 : (sc == 2) ? 512 : 2048;
        if (ty == 0 || cn == 0) return 3;
        if (ty == 2 && !nv) return 3;
        if (ty == 3 && nv) return 3;
        return cn * t + 2;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int ty, int cn, int sc);
        cfg_type = ty[1:0]; cfg_count = cn[3:0]; cfg_scale = sc[1:0];
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hold(bit v);
        pad_i = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic meas(bit nv, int lim, output int k);
        pad_i = nv;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (level_o !== nv && k < lim);
    endtask

    task automatic lat_case(string req, int ty, int cn, int sc, bit nv);
        int k, e;
        hold(!nv);
        wr(ty, cn, sc);
        e = exp_lat(ty, cn, sc, nv);
        meas(nv, e + 20, k);
        chk(k == e, req, k, e);
    endtask

    initial begin
        int k;
        bit seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(level_o === 1'b0, "R1 reset level", level_o, 0);
        rst_n = 1'b1;
        pad_i = 1'b1;
        meas(1'b1, 20, k);
        chk(k == 3, "R1 default bypass", k, 3);

        lat_case("R2 bypass rise", 0, 9, 3, 1'b1);
        lat_case("R2 bypass fall", 0, 15, 2, 1'b0);
        lat_case("R3 scale0 tick", 1, 1, 0, 1'b1);
        lat_case("R3 scale1 tick", 1, 1, 1, 1'b1);
        lat_case("R3 scale2 tick", 1, 1, 2, 1'b0);
        lat_case("R3 scale3 tick", 1, 1, 3, 1'b1);
        lat_case("R4 both rise", 1, 5, 1, 1'b1);
        lat_case("R4 both fall", 1, 15, 0, 1'b0);
        lat_case("R6 keep-low rise", 2, 2, 0, 1'b1);
        lat_case("R6 keep-low fall", 2, 2, 0, 1'b0);
        lat_case("R7 keep-high rise", 3, 2, 0, 1'b1);
        lat_case("R7 keep-high fall", 3, 2, 0, 1'b0);
        lat_case("R9 zero count rise", 1, 0, 1, 1'b1);
        lat_case("R9 zero count fall", 2, 0, 3, 1'b0);

        // R5: pulse shorter than a 24-cycle window is rejected
        hold(1'b0);
        wr(1, 3, 1);
        pad_i = 1'b1;
        repeat (20) @(negedge clk);
        pad_i = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (level_o) seen = 1'b1;
        end
        chk(!seen, "R5 short pulse rejected", seen, 0);
        // R5: reversal restarts the count
        pad_i = 1'b1;
        repeat (15) @(negedge clk);
        pad_i = 1'b0;
        repeat (2) @(negedge clk);
        meas(1'b1, 60, k);
        chk(k == 26, "R5 restart after reversal", k, 26);

        // R8: write mid-window loads the synchronised level
        hold(1'b0);
        wr(1, 15, 3);
        pad_i = 1'b1;
        repeat (10) @(negedge clk);
        chk(level_o === 1'b0, "R8 still filtering", level_o, 0);
        wr(1, 15, 3);
        chk(level_o === 1'b1, "R8 load on write", level_o, 1);

        for (int n = 0; n < 30; n++) begin
            int ty, cn, sc;
            bit nv;
            ty = $urandom_range(0, 3);
            cn = $urandom_range(0, 5);
            sc = $urandom_range(0, 1);
            nv = 1'($urandom_range(0, 1));
            case (ty)
                0: lat_case("R2 random", ty, cn, sc, nv);
                1: lat_case("R4 random", ty, cn, sc, nv);
                2: lat_case("R6 random", ty, cn, sc, nv);
                default: lat_case("R7 random", ty, cn, sc, nv);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule